// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Slice

This block is one channel of a byte-wide DMA controller. A host programs it through an 8-bit register port. The 16-bit start address and the 16-bit transfer count each take two accesses to their port. A shared byte pointer decides whether an access reaches the low byte or the high byte. The pointer toggles on every access to either wide port, and a write of any value to a dedicated port sends it back to the low byte. Two further byte ports supply memory address bits 23:16 and 31:24. These page bits stay fixed while the channel runs.

Once the channel is unmasked and holds a valid mode, it answers a peripheral request with a one-cycle acknowledge. During that cycle it drives the memory address and the transfer direction, so the byte moves directly between the peripheral and memory. Each acknowledged byte raises the address by one and lowers the count by one. The host loads the count with the length minus one. The last byte is the one acknowledged while the count is zero. On that byte the channel pulses terminal count to the peripheral, latches its bit in the status byte and masks itself. Reading the status byte clears the latched bit.

Top module: `dma_channel_slice`

## Requirements
- R1: After reset the address, count, page bytes and mode read as zero, the byte pointer selects the low byte, the channel is masked (mask port reads 1 in bit 0), the status byte reads zero and acknowledge and terminal count are low.
- R2: A write of any data to the pointer-clear port (select 6) makes the next address or count access (select 0 or 1) take the low byte (bits 7:0) and the one after take the high byte (bits 15:8); the pointer is shared by both ports.
- R3: Address and count are loaded one byte per write through select 0 and select 1, under the shared pointer; a host byte write to a register takes precedence over its step in the same cycle.
- R4: The memory address is {page high (select 3), page low (select 2), address}; page bytes never change during transfers, and address 0xFFFF steps to 0x0000 with the page unchanged.
- R5: A mode write (select 4) is taken only when its bits 1:0 equal the channel number (2); bits 3:2 = 01 means peripheral-to-memory (mem_write high), 10 means memory-to-peripheral (mem_write low), and 00 or 11 means requests are never acknowledged; the mode reads back on select 4.
- R6: A mask write (select 5) is taken only when bits 1:0 equal the channel number; bit 2 set masks and bit 2 clear unmasks; a masked channel issues no new acknowledge; select 5 reads the mask in bit 0.
- R7: With the channel unmasked, a valid mode and dreq high on a clock edge where acknowledge is low, acknowledge is high for exactly one following cycle; each acknowledge steps the address up by one and the count down by one.
- R8: A count loaded with N-1 gives exactly N acknowledges; terminal count is high only during the last one, after which the status bit and the mask are both set.
- R9: A status read (select 7) returns the terminal-count flags in bits 3:0 (only bit 2 can be set) with zero above, and clears the flag; a flag set in the same cycle survives.
- R10: Reads of select 0 or 1 return the byte chosen by the pointer and toggle the pointer, as writes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_sel | input | 3 | Register port select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected port |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge; one byte moves in this cycle |
| tc | output | 1 | Terminal-count pulse, high with the last acknowledge |
| mem_addr | output | 32 | Memory byte address, valid while dack is high |
| mem_write | output | 1 | High when the byte goes into memory |

## Verification
The transfer path is exercised with dreq held high, with dreq following a two-on, one-off pattern, and with the host masking the channel partway through. The first pattern shows the one-cycle gap between acknowledges. The second shows that a request arriving in the gap is not lost. The third shows that masking stops new grants while the count is still nonzero. Runs begin at a mid-range address and at 0xFFFF, which distinguishes a 16-bit wrap from a carry into the page bytes. Writes of mode and mask that name another channel, a mode with no valid direction, and a pointer access that jumps from the address port to the count port check that decoding and the shared pointer act on their own fields.

// File: rtl/dma_slice_pkg.sv
package dma_slice_pkg;
   typedef enum logic [2:0] {
      PORT_ADDR    = 3'd0,
      PORT_COUNT   = 3'd1,
      PORT_PAGE_LO = 3'd2,
      PORT_PAGE_HI = 3'd3,
      PORT_MODE    = 3'd4,
      PORT_MASK    = 3'd5,
      PORT_PTR_CLR = 3'd6,
      PORT_STATUS  = 3'd7
   } port_sel_e;

   typedef enum logic [1:0] {
      XT_NONE      = 2'd0,
      XT_TO_MEM    = 2'd1,
      XT_FROM_MEM  = 2'd2,
      XT_ILLEGAL   = 2'd3
   } xfer_kind_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr #(
   parameter int BYTES = 2,
   localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [PTR_W-1:0] sel
);
   initial begin
      assert (BYTES >= 2) else $fatal(1, "byte pointer needs at least two bytes");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         sel <= '0;
      else if (clr)                       sel <= '0;
      else if (adv) begin
         if (sel == PTR_W'(BYTES - 1))    sel <= '0;
         else                             sel <= sel + PTR_W'(1);
      end
   end

   AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (sel == '0)); // R2
   AST_PTR_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n) (!clr && !adv) |=> $stable(sel)); // R2
endmodule

// File: rtl/dma_wide_reg.sv
module dma_wide_reg #(
   parameter int BYTE_W  = 8,
   parameter int BYTES   = 2,
   parameter bit STEP_UP = 1'b1,
   localparam int VAL_W  = BYTE_W * BYTES,
   localparam int PTR_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PTR_W-1:0]  byte_sel,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              step,
   output logic [VAL_W-1:0]  value,
   output logic [BYTE_W-1:0] rd_byte
);
   logic [VAL_W-1:0] stepped;
   logic [VAL_W-1:0] value_d;

   initial begin
      assert (BYTE_W >= 1 && BYTES >= 2) else $fatal(1, "wide register shape invalid");
   end

   generate
      if (STEP_UP) begin : g_up
         assign stepped = value + VAL_W'(1);
      end else begin : g_down
         assign stepped = value - VAL_W'(1);
      end
   endgenerate

   always_comb begin
      value_d = value;
      if (load) begin
         for (int i = 0; i < BYTES; i++) begin
            if (byte_sel == PTR_W'(i)) value_d[i*BYTE_W +: BYTE_W] = wdata;
         end
      end else if (step) begin
         value_d = stepped;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) value <= '0;
      else        value <= value_d;
   end

   assign rd_byte = value[byte_sel*BYTE_W +: BYTE_W];

   generate
      if (STEP_UP) begin : g_chk_up
         AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (step && !load) |=> (value == $past(value) + VAL_W'(1))); // R7
      end else begin : g_chk_down
         AST_STEP_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n) (step && !load) |=> (value == $past(value) - VAL_W'(1))); // R7
      end
   endgenerate
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!step && !load) |=> $stable(value)); // R3
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
   import dma_slice_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int NUM_CHAN = 4,
   parameter int CHAN     = 2,
   localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_wr,
   input  logic                mask_wr,
   input  logic                status_rd,
   input  logic [BYTE_W-1:0]   wdata,
   input  logic                dreq,
   input  logic                cnt_zero,
   output logic                dack,
   output logic                tc,
   output logic                mem_write,
   output logic                masked,
   output logic [BYTE_W-1:0]   mode,
   output logic [NUM_CHAN-1:0] flags
);
   logic       hit;
   logic       grant;
   xfer_kind_e kind;

   initial begin
      assert (CHAN < NUM_CHAN) else $fatal(1, "channel number out of range");
      assert (CH_W + 2 <= BYTE_W) else $fatal(1, "mode fields exceed byte");
      assert (NUM_CHAN < BYTE_W) else $fatal(1, "status flags exceed byte");
   end

   assign hit       = (wdata[CH_W-1:0] == CH_W'(CHAN));
   assign kind      = xfer_kind_e'(mode[CH_W+1:CH_W]);
   assign mem_write = (kind == XT_TO_MEM);
   assign grant     = !dack && !masked && dreq && (kind == XT_TO_MEM || kind == XT_FROM_MEM);
   assign tc        = dack && cnt_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= '0;
         masked <= 1'b1;
         dack   <= 1'b0;
      end else begin
         dack <= grant;
         if (mode_wr && hit) mode <= wdata;
         if (tc)                  masked <= 1'b1;
         else if (mask_wr && hit) masked <= wdata[CH_W];
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_flag
         if (gi == CHAN) begin : g_own
            always_ff @(posedge clk) begin
               if (!rst_n)         flags[gi] <= 1'b0;
               else if (tc)        flags[gi] <= 1'b1;
               else if (status_rd) flags[gi] <= 1'b0;
            end
         end else begin : g_other
            assign flags[gi] = 1'b0;
         end
      end
   endgenerate

   AST_ACK_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) dack |=> !dack); // R7
   AST_ACK_HAS_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(dack) |-> ($past(dreq) && !$past(masked))); // R7
   AST_TC_SETS_STATE:  assert property (@(posedge clk) disable iff (!rst_n) tc |=> (masked && flags[CHAN])); // R8
   AST_MASKED_NO_ACK:  assert property (@(posedge clk) disable iff (!rst_n) (masked && !dack) |=> !dack); // R6
   AST_FLAG_ONEHOT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flags)); // R9
endmodule

// File: rtl/dma_channel_slice.sv
module dma_channel_slice
   import dma_slice_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int REG_BYTES  = 2,
   parameter int PAGE_BYTES = 2,
   parameter int NUM_CHAN   = 4,
   parameter int CHAN       = 2,
   localparam int ADDR_W    = BYTE_W * REG_BYTES,
   localparam int PAGE_W    = BYTE_W * PAGE_BYTES,
   localparam int MEM_AW    = ADDR_W + PAGE_W,
   localparam int PTR_W     = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [2:0]        host_sel,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic              dreq,
   output logic              dack,
   output logic              tc,
   output logic [MEM_AW-1:0] mem_addr,
   output logic              mem_write
);
   port_sel_e             sel;
   logic [PTR_W-1:0]      ptr;
   logic                  ptr_adv, ptr_clr;
   logic                  addr_ld, cnt_ld;
   logic [ADDR_W-1:0]     addr_q, cnt_q;
   logic [BYTE_W-1:0]     addr_byte, cnt_byte;
   logic [PAGE_W-1:0]     page_q;
   logic                  masked;
   logic [BYTE_W-1:0]     mode;
   logic [NUM_CHAN-1:0]   flags;
   logic                  page_wr;

   initial begin
      assert (PAGE_BYTES == 2) else $fatal(1, "two page ports are decoded");
   end

   assign sel     = port_sel_e'(host_sel);
   assign ptr_adv = (host_wr || host_rd) && (sel == PORT_ADDR || sel == PORT_COUNT);
   assign ptr_clr = host_wr && (sel == PORT_PTR_CLR);
   assign addr_ld = host_wr && (sel == PORT_ADDR);
   assign cnt_ld  = host_wr && (sel == PORT_COUNT);
   assign page_wr = host_wr && (sel == PORT_PAGE_LO || sel == PORT_PAGE_HI);

   dma_byte_ptr #(.BYTES(REG_BYTES)) i_ptr (
      .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(ptr_adv), .sel(ptr)
   );

   dma_wide_reg #(.BYTE_W(BYTE_W), .BYTES(REG_BYTES), .STEP_UP(1'b1)) i_addr (
      .clk(clk), .rst_n(rst_n), .load(addr_ld), .byte_sel(ptr), .wdata(host_wdata),
      .step(dack), .value(addr_q), .rd_byte(addr_byte)
   );

   dma_wide_reg #(.BYTE_W(BYTE_W), .BYTES(REG_BYTES), .STEP_UP(1'b0)) i_count (
      .clk(clk), .rst_n(rst_n), .load(cnt_ld), .byte_sel(ptr), .wdata(host_wdata),
      .step(dack), .value(cnt_q), .rd_byte(cnt_byte)
   );

   generate
      for (genvar gp = 0; gp < PAGE_BYTES; gp++) begin : g_page
         always_ff @(posedge clk) begin
            if (!rst_n)
               page_q[gp*BYTE_W +: BYTE_W] <= '0;
            else if (host_wr && host_sel == 3'(int'(PORT_PAGE_LO) + gp))
               page_q[gp*BYTE_W +: BYTE_W] <= host_wdata;
         end
      end
   endgenerate

   dma_xfer_ctrl #(.BYTE_W(BYTE_W), .NUM_CHAN(NUM_CHAN), .CHAN(CHAN)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .mode_wr(host_wr && sel == PORT_MODE),
      .mask_wr(host_wr && sel == PORT_MASK),
      .status_rd(host_rd && sel == PORT_STATUS),
      .wdata(host_wdata), .dreq(dreq), .cnt_zero(cnt_q == '0),
      .dack(dack), .tc(tc), .mem_write(mem_write), .masked(masked),
      .mode(mode), .flags(flags)
   );

   assign mem_addr = {page_q, addr_q};

   always_comb begin
      case (sel)
         PORT_ADDR:    host_rdata = addr_byte;
         PORT_COUNT:   host_rdata = cnt_byte;
         PORT_PAGE_LO: host_rdata = page_q[BYTE_W-1:0];
         PORT_PAGE_HI: host_rdata = page_q[PAGE_W-1:PAGE_W-BYTE_W];
         PORT_MODE:    host_rdata = mode;
         PORT_MASK:    host_rdata = {{(BYTE_W-1){1'b0}}, masked};
         PORT_STATUS:  host_rdata = {{(BYTE_W-NUM_CHAN){1'b0}}, flags};
         default:      host_rdata = '0;
      endcase
   end

   AST_PAGE_FIXED:  assert property (@(posedge clk) disable iff (!rst_n) (dack && !page_wr) |=> $stable(mem_addr[MEM_AW-1:ADDR_W])); // R4
   AST_TC_ON_LAST:  assert property (@(posedge clk) disable iff (!rst_n) (tc && !cnt_ld) |=> (cnt_q == '1)); // R8
endmodule

// File: tb/test_dma_channel_slice.sv
module test_dma_channel_slice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0]  host_sel = 3'd0;
   logic [7:0]  host_wdata = 8'd0;
   logic [7:0]  host_rdata;
   logic        dreq = 1'b0;
   logic        dack, tc, mem_write;
   logic [31:0] mem_addr;

   int n_chk = 0, n_err = 0, n_dack = 0, n_tc = 0, cyc = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [15:0] m_addr, m_cnt;
   logic [7:0]  m_plo, m_phi, m_mode;
   logic        m_ptr, m_mask, m_flag, m_dack, m_nxt;

   always #4 clk = ~clk;

   dma_channel_slice i_dma_channel_slice (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dreq(dreq), .dack(dack), .tc(tc), .mem_addr(mem_addr), .mem_write(mem_write)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_addr = 0; m_cnt = 0; m_plo = 0; m_phi = 0; m_mode = 0;
         m_ptr = 0; m_mask = 1; m_flag = 0; m_dack = 0;
      end else begin
         m_nxt = !m_dack && !m_mask && dreq && (m_mode[3:2] == 2'b01 || m_mode[3:2] == 2'b10);
         if (m_dack && !(host_wr && host_sel == 3'd0)) m_addr = m_addr + 16'd1;
         if (m_dack && !(host_wr && host_sel == 3'd1)) m_cnt  = m_cnt - 16'd1;
         if (host_wr) begin
            case (host_sel)
               3'd0: if (m_ptr) m_addr[15:8] = host_wdata; else m_addr[7:0] = host_wdata;
               3'd1: if (m_ptr) m_cnt[15:8]  = host_wdata; else m_cnt[7:0]  = host_wdata;
               3'd2: m_plo = host_wdata;
               3'd3: m_phi = host_wdata;
               3'd4: if (host_wdata[1:0] == 2'd2) m_mode = host_wdata;
               3'd5: if (host_wdata[1:0] == 2'd2) m_mask = host_wdata[2];
               3'd6: m_ptr = 1'b0;
               default: ;
            endcase
         end
         if ((host_wr || host_rd) && (host_sel == 3'd0 || host_sel == 3'd1)) m_ptr = ~m_ptr;
         if (host_rd && host_sel == 3'd7) m_flag = 1'b0;
         if (m_dack && m_cnt == 16'hFFFF && !(host_wr && host_sel == 3'd1)) begin
            m_flag = 1'b1; m_mask = 1'b1;
         end
         m_dack = m_nxt;
      end
   end

   // per-clock comparison against the reference (count already stepped in model, so tc uses pre-step view)
   logic [15:0] m_cnt_seen;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R7 dack", dack, m_dack);
         chk("R8 tc", tc, m_dack && m_cnt == 16'd0);
         chk("R4 mem_addr", mem_addr, {m_phi, m_plo, m_addr});
         chk("R5 mem_write", mem_write, m_mode[3:2] == 2'b01);
         if (dack) n_dack++;
         if (tc)   n_tc++;
      end
   end

   task automatic wr(logic [2:0] s, logic [7:0] d);
      host_wr = 1'b1; host_sel = s; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(string req, logic [2:0] s, logic [7:0] exp);
      host_rd = 1'b1; host_sel = s;
      #1;
      chk(req, host_rdata, exp);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      while (cyc < 20000 && !done) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int d0, t0, hold;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 dack", dack, 1'b0);
      chk("R1 tc", tc, 1'b0);
      chk("R1 mem_addr", mem_addr, 32'h0);
      rd("R1 status", 3'd7, 8'h00);
      rd("R1 mask", 3'd5, 8'h01);
      rd("R1 mode", 3'd4, 8'h00);
      rd("R1 addr low", 3'd0, 8'h00);

      // R3 R4 programming
      wr(3'd6, 8'hA5);
      wr(3'd0, 8'h34); wr(3'd0, 8'h12);
      wr(3'd2, 8'h56); wr(3'd3, 8'h78);
      chk("R4 page+addr", mem_addr, 32'h78561234);
      wr(3'd6, 8'h00);
      wr(3'd1, 8'h02); wr(3'd1, 8'h00);
      wr(3'd4, 8'h46);
      chk("R5 to memory", mem_write, 1'b1);
      rd("R5 mode readback", 3'd4, 8'h46);
      wr(3'd5, 8'h02);
      rd("R6 unmasked", 3'd5, 8'h00);

      // R7 R8 steady request, 3 bytes
      d0 = n_dack; t0 = n_tc;
      dreq = 1'b1; idle(12); dreq = 1'b0; idle(2);
      chk("R8 three acks", n_dack - d0, 3);
      chk("R8 one tc", n_tc - t0, 1);
      chk("R7 addr advanced", mem_addr, 32'h78561237);
      rd("R8 self masked", 3'd5, 8'h01);
      rd("R9 status flag", 3'd7, 8'h04);
      rd("R9 status cleared", 3'd7, 8'h00);
      wr(3'd6, 8'h3C);
      rd("R10 count low", 3'd1, 8'hFF);
      rd("R10 count high", 3'd1, 8'hFF);

      // R4 wrap without page carry, R5 memory-to-peripheral
      wr(3'd6, 8'h00);
      wr(3'd0, 8'hFF); wr(3'd0, 8'hFF);
      wr(3'd1, 8'h01); wr(3'd1, 8'h00);
      wr(3'd4, 8'h4A);
      chk("R5 from memory", mem_write, 1'b0);
      wr(3'd5, 8'h02);
      d0 = n_dack;
      dreq = 1'b1; idle(10); dreq = 1'b0; idle(2);
      chk("R4 two acks", n_dack - d0, 2);
      chk("R4 wrap keeps page", mem_addr, 32'h78560001);
      rd("R9 flag after wrap run", 3'd7, 8'h04);

      // R5 R6 other-channel writes ignored
      wr(3'd4, 8'h45);
      rd("R5 other channel mode ignored", 3'd4, 8'h4A);
      wr(3'd5, 8'h01);
      rd("R6 other channel mask ignored", 3'd5, 8'h01);

      // R5 invalid direction: no acknowledge
      wr(3'd4, 8'h42);
      wr(3'd6, 8'h00); wr(3'd1, 8'h05); wr(3'd1, 8'h00);
      wr(3'd5, 8'h02);
      d0 = n_dack;
      dreq = 1'b1; idle(6); dreq = 1'b0;
      chk("R5 no ack for type 00", n_dack - d0, 0);
      wr(3'd5, 8'h06);
      rd("R6 masked again", 3'd5, 8'h01);

      // R7 intermittent request, 10 bytes
      wr(3'd4, 8'h46);
      wr(3'd6, 8'h00); wr(3'd1, 8'h09); wr(3'd1, 8'h00);
      wr(3'd5, 8'h02);
      d0 = n_dack;
      for (int i = 0; i < 45; i++) begin
         dreq = (i % 3 != 0);
         @(negedge clk);
      end
      dreq = 1'b0; idle(2);
      chk("R8 ten acks intermittent", n_dack - d0, 10);
      rd("R9 flag intermittent", 3'd7, 8'h04);

      // R6 mask mid-transfer
      wr(3'd6, 8'h00); wr(3'd1, 8'h20); wr(3'd1, 8'h00);
      wr(3'd5, 8'h02);
      dreq = 1'b1; idle(5);
      wr(3'd5, 8'h06);
      idle(2);
      hold = n_dack;
      idle(6); dreq = 1'b0;
      chk("R6 mask stops acks", n_dack - hold, 0);
      rd("R8 no tc when stopped", 3'd7, 8'h00);

      // R2 shared pointer, R3 load over step already covered by model
      wr(3'd6, 8'h00); wr(3'd1, 8'h11); wr(3'd1, 8'h22);
      wr(3'd6, 8'hFF);
      wr(3'd0, 8'h33);
      rd("R2 count high after addr low", 3'd1, 8'h22);
      rd("R10 addr low after wrap of pointer", 3'd0, 8'h33);
      wr(3'd6, 8'h81);
      rd("R2 low byte after clear", 3'd1, 8'h11);

      idle(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule